// File: doc/BRIEF.md
# Triggered Multichannel Readout Sequencer

This block is the digital readout controller that sits next to an eight-channel analog detector front-end. Each channel's discriminator produces an asynchronous trigger pulse. The block synchronizes these pulses and records them in a sticky per-channel trigger mask. Once any bit is set, it pulls a shared, wired-OR, active-low service-request line. While that line is low, whether this block or another device on the same line holds it, the mask is frozen and no further triggers are recorded.

An external controller then supplies a slow readout clock. The first rising edge of that clock starts the sequence, and no conversion happens before it. The sequencer visits only the triggered channels, lowest index first. For each one it places the channel index on the analog multiplexer select, pulses the ADC start for one cycle, and waits for end-of-conversion. It then captures the 10-bit code and shifts a 13-bit word, the 3-bit channel index followed by the code, MSB first, one bit per readout-clock rising edge. After the last word it raises `done` and stays idle until reset. Reset clears the mask, releases the request line and ends any readout.

Control states: IDLE (waiting for a trigger; goes to ARMED when the mask is non-zero), ARMED (waiting for the first readout-clock edge; goes to START), START (one-cycle ADC start; goes to WAIT_EOC), WAIT_EOC (goes to SHIFT when end-of-conversion arrives and the code is captured), SHIFT (one bit per readout-clock edge; after the 13th bit goes to START for the next triggered channel, or to DONE), DONE (stays there until reset).

Top module: `trig_readout_seq`

## Requirements
- R1: `srq_pull_low` is 0 while no trigger bit is recorded. It is 1 from the cycle after the first trigger bit is recorded and stays 1 until reset.
- R2: A trigger input held high for at least 3 clock cycles, while `srq_line_n` is high, sets its channel's bit (bit i = channel i). That bit stays set until reset, so the channel is read out.
- R3: While `srq_line_n` is low, whether driven by this block or by another device, no new trigger bit is recorded. A channel that fires later is not read out.
- R4: No ADC start is issued before the first rising edge of `rd_clk` after a trigger. Readout-clock edges arriving with an empty trigger mask have no effect.
- R5: Only channels whose bits are set are converted, in ascending index order. `adc_start` is a pulse exactly one clock wide, and `mux_sel` carries the channel index (0..7) while it is high.
- R6: After `adc_eoc` the code on `adc_code` is captured. The word {channel[2:0], code[9:0]} (13 bits, channel index in the top 3 bits) is sent MSB first on `data_out`. One bit goes out per `rd_clk` rising edge, appears within 4 clock cycles of that edge, and holds until the next edge.
- R7: After the last triggered channel's final bit, `done` is 1. Further `rd_clk` edges cause no ADC start, and `done` stays 1 until reset.
- R8: Asserting `rst_n` low clears the trigger mask, `done`, `srq_pull_low`, `adc_start` and `data_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears triggers and ends readout |
| trig_in | input | 8 | Asynchronous per-channel discriminator triggers |
| srq_line_n | input | 1 | Sensed level of the shared active-low service-request line |
| srq_pull_low | output | 1 | 1 = pull the shared request line low (open-drain enable) |
| rd_clk | input | 1 | External readout clock, asynchronous and slow |
| adc_start | output | 1 | One-cycle conversion start pulse |
| mux_sel | output | 3 | Analog multiplexer channel select |
| adc_eoc | input | 1 | End-of-conversion strobe from the ADC |
| adc_code | input | 10 | Parallel conversion result, valid with `adc_eoc` |
| data_out | output | 1 | Serial result data |
| done | output | 1 | All triggered channels have been sent |

## Verification
The bench attacks the freeze window in two ways. A second channel fires after the line is already low, and another device holds the line while all eight channels fire. A design that froze late or ignored the line's external state would read out extra channels. Readout-clock edges are sent before any trigger and again after `done`, because a sequencer that reacted to them would start spurious conversions or drop its done flag. Single-channel masks at both ends, the full mask and random masks check ascending order, the channel-index prefix and the bit order, which a wrong priority encoder or serializer would corrupt.

// File: rtl/trs_pkg.sv
package trs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_START,
        ST_WAIT_EOC,
        ST_SHIFT,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/trs_sync.sv
module trs_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_in;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/trs_trig_reg.sv
module trs_trig_reg #(
    parameter int N_CH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] trig_sync,
    input  logic            freeze,
    output logic [N_CH-1:0] trig_mask
);
    logic [N_CH-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (!freeze) begin
            mask_q <= mask_q | trig_sync;
        end
    end

    assign trig_mask = mask_q;

    // R3: a low request line blocks any change to the recorded triggers
    a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> (mask_q == $past(mask_q)));
endmodule

// File: rtl/trs_serializer.sv
module trs_serializer #(
    parameter int WORD_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              shift_en,
    output logic              data_out,
    output logic              last_bit
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [WORD_W-1:0] sh_q;
    logic [CNT_W-1:0]  left_q;
    logic              data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
            data_q <= 1'b0;
        end else if (load) begin
            sh_q   <= word;
            left_q <= CNT_W'(WORD_W);
        end else if (shift_en && left_q != '0) begin
            data_q <= sh_q[WORD_W-1];
            sh_q   <= {sh_q[WORD_W-2:0], 1'b0};
            left_q <= left_q - 1'b1;
        end
    end

    assign data_out = data_q;
    assign last_bit = (left_q == CNT_W'(1));
endmodule

// File: rtl/trig_readout_seq.sv
module trig_readout_seq #(
    parameter int N_CH        = 8,
    parameter int CODE_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_CH-1:0]           trig_in,
    input  logic                      srq_line_n,
    output logic                      srq_pull_low,
    input  logic                      rd_clk,
    output logic                      adc_start,
    output logic [$clog2(N_CH)-1:0]   mux_sel,
    input  logic                      adc_eoc,
    input  logic [CODE_W-1:0]         adc_code,
    output logic                      data_out,
    output logic                      done
);
    import trs_pkg::*;

    localparam int CH_W   = $clog2(N_CH);
    localparam int WORD_W = CH_W + CODE_W;

    seq_state_t      state_q, state_d;
    logic [N_CH-1:0] trig_sync, trig_mask;
    logic            rd_sync, rd_prev_q, rd_rise;
    logic [N_CH-1:0] pending_q, rest_mask, cur_onehot;
    logic [CH_W-1:0] cur_ch_q;
    logic            last_bit, shift_en, load_word;

    function automatic logic [CH_W-1:0] first_set(input logic [N_CH-1:0] m);
        first_set = '0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (m[i]) first_set = i[CH_W-1:0];
        end
    endfunction

    trs_sync #(.WIDTH(N_CH), .STAGES(SYNC_STAGES)) u_trig_sync (
        .clk(clk), .rst_n(rst_n), .async_in(trig_in), .sync_out(trig_sync)
    );

    trs_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_rd_sync (
        .clk(clk), .rst_n(rst_n), .async_in(rd_clk), .sync_out(rd_sync)
    );

    trs_trig_reg #(.N_CH(N_CH)) u_trig_reg (
        .clk(clk), .rst_n(rst_n), .trig_sync(trig_sync),
        .freeze(!srq_line_n), .trig_mask(trig_mask)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_prev_q <= 1'b0;
        else        rd_prev_q <= rd_sync;
    end

    assign rd_rise    = rd_sync && !rd_prev_q;
    assign cur_onehot = {{(N_CH-1){1'b0}}, 1'b1} << cur_ch_q;
    assign rest_mask  = pending_q & ~cur_onehot;
    assign shift_en   = (state_q == ST_SHIFT) && rd_rise;
    assign load_word  = (state_q == ST_WAIT_EOC) && adc_eoc;

    trs_serializer #(.WORD_W(WORD_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .load(load_word),
        .word({cur_ch_q, adc_code}), .shift_en(shift_en),
        .data_out(data_out), .last_bit(last_bit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (trig_mask != '0) state_d = ST_ARMED;
            ST_ARMED:    if (rd_rise) state_d = ST_START;
            ST_START:    state_d = ST_WAIT_EOC;
            ST_WAIT_EOC: if (adc_eoc) state_d = ST_SHIFT;
            ST_SHIFT:    if (rd_rise && last_bit)
                             state_d = (rest_mask == '0) ? ST_DONE : ST_START;
            ST_DONE:     state_d = ST_DONE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Channel bookkeeping for the sequence
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q <= '0;
            cur_ch_q  <= '0;
        end else if (state_q == ST_ARMED && rd_rise) begin
            pending_q <= trig_mask;
            cur_ch_q  <= first_set(trig_mask);
        end else if (shift_en && last_bit) begin
            pending_q <= rest_mask;
            cur_ch_q  <= first_set(rest_mask);
        end
    end

    assign adc_start    = (state_q == ST_START);
    assign mux_sel      = cur_ch_q;
    assign done         = (state_q == ST_DONE);
    assign srq_pull_low = (trig_mask != '0);

    // R1: a conversion is only ever started while this block requests service
    a_r1_start_with_request: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> srq_pull_low);

    // R2: recorded trigger bits never clear before reset
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((trig_mask & $past(trig_mask)) == $past(trig_mask)));

    // R5: start is one cycle wide and targets a pending channel
    a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);
    a_r5_start_pending: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> pending_q[mux_sel]);

    // R6: serial data changes only on a readout-clock edge
    a_r6_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_rise |=> $stable(data_out));

    // R7: done is final until reset and no conversion follows it
    a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && !adc_start));
endmodule

// File: tb/tb_trig_readout_seq.sv
module tb_trig_readout_seq;
    localparam int N_CH = 8;
    localparam int CODE_W = 10;
    localparam int WORD_W = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N_CH-1:0] trig_in = '0;
    logic ext_pull = 1'b0;
    logic rd_clk = 1'b0;
    logic adc_eoc = 1'b0;
    logic [CODE_W-1:0] adc_code = '0;
    logic srq_pull_low, adc_start, data_out, done, srq_line_n;
    logic [2:0] mux_sel;

    int nchk = 0, nerr = 0;
    int conv_n = 0, start_long = 0;
    logic [2:0] conv_log [256];
    logic [CODE_W-1:0] codes [N_CH];
    logic prev_start = 1'b0;
    int eoc_cnt = 0;
    logic [2:0] adc_ch = '0;

    always #10 clk = ~clk;

    assign srq_line_n = ~(srq_pull_low | ext_pull);

    trig_readout_seq dut (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .srq_line_n(srq_line_n),
        .srq_pull_low(srq_pull_low), .rd_clk(rd_clk), .adc_start(adc_start),
        .mux_sel(mux_sel), .adc_eoc(adc_eoc), .adc_code(adc_code),
        .data_out(data_out), .done(done)
    );

    // ADC model, acting away from the active edge
    always @(negedge clk) begin
        if (adc_start && prev_start) start_long = start_long + 1;
        prev_start = adc_start;
        adc_eoc = 1'b0;
        if (adc_start) begin
            conv_log[conv_n % 256] = mux_sel;
            conv_n = conv_n + 1;
            adc_ch = mux_sel;
            eoc_cnt = 3;
        end else if (eoc_cnt > 0) begin
            eoc_cnt = eoc_cnt - 1;
            if (eoc_cnt == 0) begin
                adc_eoc = 1'b1;
                adc_code = codes[adc_ch];
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int popc(input logic [N_CH-1:0] m);
        int n = 0;
        for (int i = 0; i < N_CH; i++) n += int'(m[i]);
        return n;
    endfunction

    function automatic logic [WORD_W-1:0] exp_word(input int ch);
        return {ch[2:0], codes[ch]};
    endfunction

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic fire(input logic [N_CH-1:0] m);
        @(negedge clk) trig_in = m;
        repeat (4) @(negedge clk);
        trig_in = '0;
        repeat (4) @(negedge clk);
    endtask

    task automatic rd_pulse(output logic bit_seen);
        @(negedge clk) rd_clk = 1'b1;
        repeat (8) @(negedge clk);
        bit_seen = data_out;
        rd_clk = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic set_codes();
        for (int c = 0; c < N_CH; c++) codes[c] = CODE_W'($urandom);
    endtask

    task automatic readout(input logic [N_CH-1:0] m);
        int base = conv_n;
        int long0 = start_long;
        int k = 0;
        logic b;
        logic [WORD_W-1:0] w;
        repeat (30) @(negedge clk);
        chk(conv_n == base, "R4 no start before readout clock", conv_n - base, 0);
        rd_pulse(b);
        for (int c = 0; c < N_CH; c++) begin
            if (m[c]) begin
                w = '0;
                for (int i = 0; i < WORD_W; i++) begin
                    rd_pulse(b);
                    w = {w[WORD_W-2:0], b};
                end
                chk(w == exp_word(c), "R6 word ch/code MSB first", int'(w), int'(exp_word(c)));
                chk(conv_log[(base + k) % 256] == c[2:0], "R5 ascending channel order",
                    int'(conv_log[(base + k) % 256]), c);
                k++;
            end
        end
        chk(conv_n - base == popc(m), "R5 only triggered channels", conv_n - base, popc(m));
        chk(start_long == long0, "R5 start one cycle wide", start_long - long0, 0);
        chk(done == 1'b1, "R7 done after last word", int'(done), 1);
        rd_pulse(b);
        rd_pulse(b);
        chk(conv_n - base == popc(m) && done, "R7 idle after done", conv_n - base, popc(m));
    endtask

    initial begin
        logic b;
        logic [N_CH-1:0] m;
        void'($urandom(32'h51F3_0A7C));
        for (int c = 0; c < N_CH; c++) codes[c] = '0;
        repeat (3) @(negedge clk);
        chk(!srq_pull_low && !done && !adc_start && !data_out, "R8 reset state",
            int'({srq_pull_low, done, adc_start, data_out}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R4: readout clock with no trigger is ignored
        begin
            int base = conv_n;
            repeat (3) rd_pulse(b);
            chk(conv_n == base && !done, "R4 rd_clk ignored when idle", conv_n - base, 0);
        end

        // R3: another device holds the line, all triggers fire
        ext_pull = 1'b1;
        fire(8'hFF);
        repeat (4) @(negedge clk);
        ext_pull = 1'b0;
        repeat (4) @(negedge clk);
        chk(!srq_pull_low, "R3 no capture while line held externally", int'(srq_pull_low), 0);

        // R1/R2: single lowest channel
        set_codes();
        fire(8'h01);
        chk(srq_pull_low, "R1 request after trigger", int'(srq_pull_low), 1);
        readout(8'h01);
        chk(srq_pull_low, "R1 request held until reset", int'(srq_pull_low), 1);
        do_reset();
        chk(!srq_pull_low && !done && !data_out, "R8 reset clears state",
            int'({srq_pull_low, done, data_out}), 0);

        // Highest channel alone, then all channels
        set_codes();
        fire(8'h80);
        readout(8'h80);
        do_reset();
        set_codes();
        fire(8'hFF);
        readout(8'hFF);
        do_reset();

        // R3: late trigger after the line went low is not recorded
        set_codes();
        fire(8'h04);
        fire(8'h20);
        readout(8'h04);
        do_reset();

        // R2: random simultaneous masks
        for (int it = 0; it < 8; it++) begin
            m = N_CH'($urandom);
            if (m == '0) m = 8'h10;
            set_codes();
            fire(m);
            readout(m);
            do_reset();
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule